// File: doc/BRIEF.md
# Signed Immediate Compare Unit

This block executes the compare-against-immediate instruction of a fixed-width 32-bit instruction set. It takes the instruction word, one 64-bit register value and the sticky summary-overflow flag. It compares the register signed against the 16-bit immediate carried in the word and writes a 4-bit outcome into one of eight 4-bit fields of a 32-bit condition register. The register file reads its operand using the register index that this block passes out. Fetch and branching sit outside the block.

A width bit in the instruction picks the compare mode. In narrow mode the low 32 bits of the register are sign-extended before the compare. In wide mode all 64 bits are compared. The immediate is always sign-extended. The outcome records less-than, greater-than and equal, and copies the overflow flag into the fourth bit. No other state of the machine changes.

Top module: `sicmp_unit`

## Requirements
- R1: The synchronous active-low reset clears all 32 bits of `cr_o` to zero.
- R2: `accept_o` is high in the same cycle exactly when `valid_i` is high, `instr_i[31:26]` equals 11 (big-endian bits 0–5) and the reserved bit `instr_i[22]` (big-endian bit 9) is zero.
- R3: When `accept_o` is low, `cr_o` does not change at the next clock edge. This covers a low strobe, any other opcode and a set reserved bit.
- R4: When the width bit `instr_i[21]` is 0, the compared operand is `rs_val_i[31:0]` sign-extended to 64 bits, and the upper 32 bits of `rs_val_i` have no effect.
- R5: When `instr_i[21]` is 1, all 64 bits of `rs_val_i` are compared as a two's-complement number.
- R6: The immediate `instr_i[15:0]` is read as signed (−32768 to 32767) and sign-extended before the compare.
- R7: The target field index is `instr_i[25:23]`. Field k occupies `cr_o[31-4k:28-4k]`, so field 0 is the top nibble. An accepted instruction changes no other field.
- R8: Inside the target nibble, from most to least significant bit, the order is less-than, greater-than, equal, and a copy of `so_i`.
- R9: Exactly one of less-than, greater-than and equal is set. Extreme values such as 0x8000000000000000 against +1 give less-than.
- R10: An accepted instruction updates `cr_o` at the next rising clock edge.
- R11: `rs_idx_o` always equals `instr_i[20:16]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 64 | Register operand read from the register file |
| so_i | input | 1 | Sticky summary-overflow flag |
| valid_i | input | 1 | Instruction strobe |
| accept_o | output | 1 | Instruction recognised and executed this cycle |
| rs_idx_o | output | 5 | Register index sent to the register file |
| cr_o | output | 32 | Condition register, eight 4-bit fields |

## Verification
The bench sweeps every field index and both widths. For each, it crosses a set of register values with a set of immediates taken from the signed boundaries. Values whose low word is negative but which are positive as 64-bit numbers, and values whose upper word disagrees with the low word's sign, separate narrow mode from wide mode. Immediates with the top bit set show whether sign extension happens. The extreme values catch a compare built on a wrapping subtraction. Alternating the overflow flag, walking all other opcodes, setting the reserved bit, dropping the strobe and resetting in the middle of a run each check that the register holds or clears when it should.

// File: rtl/sicmp_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the signed immediate compare unit.
// Assumes a 32-bit instruction word numbered big-endian (bit 0 = MSB).
package sicmp_pkg;
    localparam int INSN_W    = 32;
    localparam int XLEN      = 64;
    localparam int NARROW_W  = 32;
    localparam int IMM_W     = 16;
    localparam int NFIELDS   = 8;
    localparam int FIELD_W   = 4;
    localparam int CR_W      = NFIELDS * FIELD_W;
    localparam int FIDX_W    = $clog2(NFIELDS);
    localparam int GIDX_W    = 5;
    localparam int OPC_W     = 6;
    localparam logic [OPC_W-1:0] OPC_CMP_IMM = 6'd11;

    // Instruction layout, most significant field first.
    typedef struct packed {
        logic [OPC_W-1:0]  opc;
        logic [FIDX_W-1:0] fidx;
        logic              rsv;
        logic              wide;
        logic [GIDX_W-1:0] ridx;
        logic [IMM_W-1:0]  imm;
    } insn_t;

    // Condition field contents, less-than in the MSB.
    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cfield_t;
endpackage

// File: rtl/sicmp_decode.sv
`timescale 1ns/1ps
// Instruction decoder: splits the word into its fields and qualifies it.
// Assumes the word layout in sicmp_pkg::insn_t. Purely combinational.
module sicmp_decode
    import sicmp_pkg::*;
(
    input  logic [INSN_W-1:0] instr_i,
    input  logic              valid_i,
    output logic              accept_o,
    output logic [FIDX_W-1:0] fidx_o,
    output logic              wide_o,
    output logic [GIDX_W-1:0] ridx_o,
    output logic [IMM_W-1:0]  imm_o
);
    insn_t word;

    // Field extraction and acceptance test.
    always_comb begin
        word     = insn_t'(instr_i);
        fidx_o   = word.fidx;
        wide_o   = word.wide;
        ridx_o   = word.ridx;
        imm_o    = word.imm;
        accept_o = valid_i && (word.opc == OPC_CMP_IMM) && !word.rsv;
    end
endmodule

// File: rtl/sicmp_compare.sv
`timescale 1ns/1ps
// Signed magnitude compare of a register against a sign-extended immediate.
// Uses relational operators on signed values, never a wrapping difference,
// so extreme operands order correctly. Combinational.
module sicmp_compare #(
    parameter int XLEN     = 64,
    parameter int NARROW_W = 32,
    parameter int IMM_W    = 16
) (
    input  logic [XLEN-1:0]  opnd_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             wide_i,
    output logic             lt_o,
    output logic             gt_o,
    output logic             eq_o
);
    localparam int NPAD = XLEN - NARROW_W;
    localparam int IPAD = XLEN - IMM_W;

    logic [XLEN-1:0] lhs;
    logic [XLEN-1:0] rhs;

    // Operand widening for the selected mode.
    always_comb begin
        if (wide_i) lhs = opnd_i;
        else        lhs = {{NPAD{opnd_i[NARROW_W-1]}}, opnd_i[NARROW_W-1:0]};
        rhs = {{IPAD{imm_i[IMM_W-1]}}, imm_i};
    end

    // Three-way signed relation.
    always_comb begin
        lt_o = $signed(lhs) <  $signed(rhs);
        gt_o = $signed(lhs) >  $signed(rhs);
        eq_o = lhs == rhs;
    end
endmodule

// File: rtl/sicmp_crfile.sv
`timescale 1ns/1ps
// Condition register: NFIELDS fields of FIELD_W bits, field 0 in the top bits.
// One field is written per enabled cycle; synchronous active-low reset.
module sicmp_crfile #(
    parameter int NFIELDS = 8,
    parameter int FIELD_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en_i,
    input  logic [$clog2(NFIELDS)-1:0] wr_idx_i,
    input  logic [FIELD_W-1:0]         wr_val_i,
    output logic [NFIELDS*FIELD_W-1:0] cr_o
);
    localparam int CR_W = NFIELDS * FIELD_W;

    for (genvar k = 0; k < NFIELDS; k++) begin : g_field
        localparam int HI = CR_W - 1 - k * FIELD_W;
        logic [FIELD_W-1:0] q;

        // Per-field storage with targeted write.
        always_ff @(posedge clk) begin
            if (!rst_n)                                    q <= '0;
            else if (wr_en_i && (int'(wr_idx_i) == k))     q <= wr_val_i;
        end

        assign cr_o[HI -: FIELD_W] = q;

        // R7: fields other than the target keep their value.
        p_untouched_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_en_i || int'(wr_idx_i) != k) |=> $stable(cr_o[HI -: FIELD_W]));
        // R10: the target field takes the new value one edge later.
        p_written_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && int'(wr_idx_i) == k) |=> cr_o[HI -: FIELD_W] == $past(wr_val_i));
    end
endmodule

// File: rtl/sicmp_unit.sv
`timescale 1ns/1ps
// Top: decodes a compare-immediate instruction, compares the register
// operand signed against the immediate and writes one condition field.
// Assumes rs_val_i already holds the register named by rs_idx_o.
module sicmp_unit
    import sicmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INSN_W-1:0] instr_i,
    input  logic [XLEN-1:0]   rs_val_i,
    input  logic              so_i,
    input  logic              valid_i,
    output logic              accept_o,
    output logic [GIDX_W-1:0] rs_idx_o,
    output logic [CR_W-1:0]   cr_o
);
    logic              acc;
    logic [FIDX_W-1:0] fidx;
    logic              wide;
    logic [IMM_W-1:0]  imm;
    logic              lt, gt, eq;
    cfield_t           res;

    sicmp_decode i_dec (
        .instr_i  (instr_i),
        .valid_i  (valid_i),
        .accept_o (acc),
        .fidx_o   (fidx),
        .wide_o   (wide),
        .ridx_o   (rs_idx_o),
        .imm_o    (imm)
    );

    sicmp_compare #(.XLEN(XLEN), .NARROW_W(NARROW_W), .IMM_W(IMM_W)) i_cmp (
        .opnd_i (rs_val_i),
        .imm_i  (imm),
        .wide_i (wide),
        .lt_o   (lt),
        .gt_o   (gt),
        .eq_o   (eq)
    );

    // Pack the relation and the overflow copy into a field value.
    always_comb begin
        res.lt = lt;
        res.gt = gt;
        res.eq = eq;
        res.so = so_i;
    end

    sicmp_crfile #(.NFIELDS(NFIELDS), .FIELD_W(FIELD_W)) i_cr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (acc),
        .wr_idx_i (fidx),
        .wr_val_i (res),
        .cr_o     (cr_o)
    );

    assign accept_o = acc;

    // R3: a rejected cycle leaves the whole register unchanged.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_o |=> $stable(cr_o));
    // R8: the lowest bit of the written field mirrors the overflow flag.
    p_so_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> cr_o[FIELD_W * (NFIELDS - 1 - int'($past(instr_i[25:23])))] == $past(so_i));
    // R9: the compare yields exactly one relation.
    p_one_rel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({lt, gt, eq}) == 1);
    // R2: a set reserved bit is never accepted.
    p_rsv_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
        instr_i[22] |-> !accept_o);
endmodule

// File: tb/test_sicmp_unit.sv
`timescale 1ns/1ps
module test_sicmp_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] rs = '0;
    logic        so = 1'b0;
    logic        valid = 1'b0;
    logic        accept;
    logic [4:0]  ridx;
    logic [31:0] cr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [31:0] model = '0;

    always #4 clk = ~clk;

    sicmp_unit i_sicmp_unit (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .rs_val_i(rs), .so_i(so),
        .valid_i(valid), .accept_o(accept), .rs_idx_o(ridx), .cr_o(cr)
    );

    logic [63:0] opnds [12] = '{
        64'h0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_7FFF_FFFF,
        64'h0000_0000_8000_0000, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF,
        64'hFFFF_FFFF_0000_0005, 64'h0000_0000_0000_7FFF, 64'hFFFF_FFFF_FFFF_8000,
        64'h0000_0001_0000_0000, 64'h0000_0000_0000_8000 };
    logic [15:0] imms [8] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF,
                              16'h8000, 16'h0005, 16'h7FFE, 16'h8001};

    // Expected nibble: offset-binary unsigned ordering of the widened values.
    function automatic logic [3:0] exp_nib(logic [63:0] r, logic [15:0] im, logic w, logic s);
        logic [63:0] a, b, ua, ub;
        a = w ? r : {{32{r[31]}}, r[31:0]};
        b = {{48{im[15]}}, im};
        ua = a ^ 64'h8000_0000_0000_0000;
        ub = b ^ 64'h8000_0000_0000_0000;
        return {ua < ub, ua > ub, ua == ub, s};
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check accept/index, then cr_o after the edge.
    task automatic apply(logic [5:0] opc, logic [2:0] f, logic rsv, logic w, logic [4:0] ra,
                         logic [15:0] im, logic [63:0] r, logic s, logic v, string tag);
        logic acc_exp;
        instr = {opc, f, rsv, w, ra, im};
        rs = r; so = s; valid = v;
        #1;
        acc_exp = v && opc == 6'd11 && !rsv;
        check("R2 accept", {63'b0, accept}, {63'b0, acc_exp});
        check("R11 rs_idx", {59'b0, ridx}, {59'b0, ra});
        if (acc_exp) model[31-4*f -: 4] = exp_nib(r, im, w, s);
        @(negedge clk);
        check(tag, {32'b0, cr}, {32'b0, model});
    endtask

    initial begin
        #1_200_000;
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", {32'b0, cr}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {32'b0, cr}, 64'h0);
        // Main sweep: field index, width, operands, immediates, overflow flag.
        for (int f = 0; f < 8; f++)
            for (int w = 0; w < 2; w++)
                for (int o = 0; o < 12; o++)
                    for (int i = 0; i < 8; i++)
                        apply(6'd11, 3'(f), 1'b0, 1'(w), 5'((o + i) % 32), imms[i], opnds[o],
                              1'((o + i + f) % 2), 1'b1,
                              w ? "R5 R6 R7 R8 R9 R10 wide" : "R4 R6 R7 R8 R9 R10 narrow");
        // R9 boundary: most negative against +1 in wide mode.
        apply(6'd11, 3'd3, 1'b0, 1'b1, 5'd7, 16'h0001, 64'h8000_0000_0000_0000, 1'b0, 1'b1, "R9 extreme");
        check("R9 lt bit", {63'b0, cr[31-12]}, 64'h1);
        // R4: upper word ignored in narrow mode.
        apply(6'd11, 3'd5, 1'b0, 1'b0, 5'd1, 16'h0005, 64'h8123_4567_0000_0005, 1'b1, 1'b1, "R4 upper ignored");
        // R3: other opcodes, reserved bit, low strobe.
        for (int op = 0; op < 64; op++)
            if (op != 11)
                apply(6'(op), 3'(op % 8), 1'b0, 1'(op % 2), 5'(op % 32), 16'h1234, 64'(op), 1'b1, 1'b1, "R3 other opcode");
        apply(6'd11, 3'd2, 1'b1, 1'b0, 5'd9, 16'h0000, 64'h5, 1'b1, 1'b1, "R3 reserved bit");
        apply(6'd11, 3'd2, 1'b0, 1'b0, 5'd9, 16'h0000, 64'h5, 1'b1, 1'b0, "R3 strobe low");
        // R1: reset in mid-run clears the register.
        rst_n = 1'b0;
        valid = 1'b1;
        @(negedge clk);
        model = '0;
        check("R1 mid-run reset", {32'b0, cr}, 64'h0);
        valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        apply(6'd11, 3'd0, 1'b0, 1'b0, 5'd31, 16'hFFFF, 64'h0, 1'b1, 1'b1, "R7 R8 field0 top");
        check("R7 field0 nibble", {60'b0, cr[31:28]}, 64'h5);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule